// File: doc/BRIEF.md
# Gate-Level Testability Cost Evaluator

This block computes heuristic testability figures for a small combinational netlist kept in internal tables. A host fills a gate table one slot per write. Each slot holds a gate kind, up to two source node indices and one destination node index, and the slots must be in topological order. The host then pulses `start` along with the number of slots to use.

The block makes a forward sweep over the slots, one gate per cycle. This sweep gives every node a cost for driving it to 0 and a cost for driving it to 1. A reverse sweep, again one gate per cycle, then gives every node a cost for making its value visible at an output. When the reverse sweep ends, `done` rises. For any node, the host can read its two drive costs, its visibility cost and its stuck-at testability figures through a combinational indexed read port.

Costs are 8-bit unsigned numbers and saturate at 255. A node that no gate drives counts as a primary input. A node that no gate reads counts as a primary output.

Top module: `tev_evaluator`

## Requirements
- R1: After reset, `done` and `busy` are low, and every node reads drive costs of 1, a visibility cost of 1 and testability figures of 2.
- R2: A node that no active gate drives has a 0-cost and a 1-cost of 1.
- R3: For gate kind AND (code 2'b00) the output 0-cost is min(source 0-costs)+1 and the output 1-cost is the sum of the source 1-costs plus 1.
- R4: For gate kind OR (code 2'b01) the output 1-cost is min(source 1-costs)+1 and the output 0-cost is the sum of the source 0-costs plus 1.
- R5: For gate kind NOT (code 2'b10) the output 0-cost is the source-A 1-cost plus 1 and the output 1-cost is the source-A 0-cost plus 1. Source B has no effect on any result.
- R6: For gate kind XOR (code 2'b11) the output 0-cost is min(sum of both 0-costs, sum of both 1-costs)+1 and the output 1-cost is min(A0+B1, A1+B0)+1.
- R7: A node read by no active gate has a visibility cost of 1.
- R8: An AND source costs the output visibility plus the other source's 1-cost plus 1. An OR source costs the output visibility plus the other source's 0-cost plus 1.
- R9: A NOT source, and each XOR source, costs the output visibility plus 1.
- R10: A node read more than once (by several gates, or by both sources of one gate) takes the smallest of its candidate visibility costs.
- R11: The stuck-at-0 figure of a node is its 1-cost plus its visibility cost. The stuck-at-1 figure is its 0-cost plus its visibility cost.
- R12: Every cost and figure saturates at 255 instead of wrapping.
- R13: If `start` is sampled at a rising edge E0 while idle, `done` is first high after edge E0+2N+1, where N is the effective gate count. `start` clears `done`. While `busy` is high, table writes and further `start` pulses are ignored. Results stay unchanged until the next accepted `start`.
- R14: Only the first N slots take part, where N is `num_gates` limited to MAX_GATES. With N=0 every node reads costs of 1 and a visibility cost of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write one gate slot (accepted only when idle) |
| wr_slot | input | $clog2(MAX_GATES) | Slot index to write |
| wr_kind | input | 2 | Gate kind: 00 AND, 01 OR, 10 NOT, 11 XOR |
| wr_src_a | input | $clog2(NODES) | First source node |
| wr_src_b | input | $clog2(NODES) | Second source node (unused by NOT) |
| wr_dst | input | $clog2(NODES) | Destination node |
| start | input | 1 | Begin an evaluation when idle |
| num_gates | input | $clog2(MAX_GATES+1) | Number of slots to evaluate, sampled with start |
| busy | output | 1 | Evaluation in progress |
| done | output | 1 | Results valid |
| rd_node | input | $clog2(NODES) | Node index to read |
| rd_cost0 | output | 8 | Cost to drive the node to 0 |
| rd_cost1 | output | 8 | Cost to drive the node to 1 |
| rd_obs | output | 8 | Cost to observe the node |
| rd_test_sa0 | output | 8 | Stuck-at-0 testability figure |
| rd_test_sa1 | output | 8 | Stuck-at-1 testability figure |

## Verification
A hand-built netlist with one gate of each kind tests each recurrence separately. Its NOT gate has a stray second source, which shows whether source B leaks into the result. A node with two readers shows whether the minimum or the last candidate is kept. A chain of self-fed AND gates doubles the 1-cost until it hits the ceiling, which separates saturation from wrap-around. Random topological netlists with several primary inputs and mixed gate kinds give reconverging paths that no directed case covers. A run with fewer gates than loaded, a run with zero gates, and writes and start pulses issued mid-run each check that the slot count and the busy lockout hold.

// File: rtl/tev_pkg.sv
package tev_pkg;

    localparam int COST_W = 8;
    localparam int SUM_W  = COST_W + 2;

    typedef logic [COST_W-1:0] cost_t;
    typedef logic [SUM_W-1:0]  wide_t;

    localparam cost_t COST_MAX = '1;
    localparam cost_t COST_ONE = cost_t'(1);

    typedef enum logic [1:0] {
        GK_AND = 2'b00,
        GK_OR  = 2'b01,
        GK_NOT = 2'b10,
        GK_XOR = 2'b11
    } gate_kind_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_FWD,
        PH_BWD,
        PH_FIN
    } phase_e;

    // Drive costs of one node.
    typedef struct packed {
        cost_t c0;
        cost_t c1;
    } drive_pair_t;

    localparam drive_pair_t PAIR_INIT = '{c0: COST_ONE, c1: COST_ONE};

    function automatic wide_t widen(cost_t v);
        return {{(SUM_W-COST_W){1'b0}}, v};
    endfunction

    function automatic cost_t clamp(wide_t v);
        return (v > widen(COST_MAX)) ? COST_MAX : v[COST_W-1:0];
    endfunction

    function automatic cost_t cmin(cost_t a, cost_t b);
        return (a < b) ? a : b;
    endfunction

    function automatic cost_t add3(cost_t a, cost_t b, cost_t c);
        return clamp(widen(a) + widen(b) + widen(c));
    endfunction

    // min(a0+b0, a1+b1) + 1, saturated
    function automatic cost_t min_sum_inc(cost_t a0, cost_t b0, cost_t a1, cost_t b1);
        wide_t s0;
        wide_t s1;
        s0 = widen(a0) + widen(b0);
        s1 = widen(a1) + widen(b1);
        return clamp(((s0 < s1) ? s0 : s1) + widen(COST_ONE));
    endfunction

endpackage

// File: rtl/tev_gate_table.sv
module tev_gate_table
    import tev_pkg::*;
#(
    parameter int SLOTS  = 16,
    parameter int NIDX_W = 4,
    parameter int SLOT_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [SLOT_W-1:0] w_slot,
    input  gate_kind_e        w_kind,
    input  logic [NIDX_W-1:0] w_a,
    input  logic [NIDX_W-1:0] w_b,
    input  logic [NIDX_W-1:0] w_dst,
    input  logic [SLOT_W-1:0] r_slot,
    output gate_kind_e        r_kind,
    output logic [NIDX_W-1:0] r_a,
    output logic [NIDX_W-1:0] r_b,
    output logic [NIDX_W-1:0] r_dst
);

    gate_kind_e        kind_q [SLOTS];
    logic [NIDX_W-1:0] a_q    [SLOTS];
    logic [NIDX_W-1:0] b_q    [SLOTS];
    logic [NIDX_W-1:0] dst_q  [SLOTS];

    logic slot_ok;
    assign slot_ok = (32'(w_slot) < SLOTS);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < SLOTS; i++) begin
                kind_q[i] <= GK_AND;
                a_q[i]    <= '0;
                b_q[i]    <= '0;
                dst_q[i]  <= '0;
            end
        end else if (we && slot_ok) begin
            kind_q[w_slot] <= w_kind;
            a_q[w_slot]    <= w_a;
            b_q[w_slot]    <= w_b;
            dst_q[w_slot]  <= w_dst;
        end
    end

    assign r_kind = kind_q[r_slot];
    assign r_a    = a_q[r_slot];
    assign r_b    = b_q[r_slot];
    assign r_dst  = dst_q[r_slot];

endmodule

// File: rtl/tev_fwd_rules.sv
module tev_fwd_rules
    import tev_pkg::*;
(
    input  gate_kind_e  kind,
    input  drive_pair_t src_a,
    input  drive_pair_t src_b,
    output drive_pair_t dst
);

    always_comb begin
        dst = PAIR_INIT;
        case (kind)
            GK_AND: begin
                dst.c0 = add3(cmin(src_a.c0, src_b.c0), '0, COST_ONE);
                dst.c1 = add3(src_a.c1, src_b.c1, COST_ONE);
            end
            GK_OR: begin
                dst.c1 = add3(cmin(src_a.c1, src_b.c1), '0, COST_ONE);
                dst.c0 = add3(src_a.c0, src_b.c0, COST_ONE);
            end
            GK_NOT: begin
                dst.c0 = add3(src_a.c1, '0, COST_ONE);
                dst.c1 = add3(src_a.c0, '0, COST_ONE);
            end
            GK_XOR: begin
                dst.c0 = min_sum_inc(src_a.c0, src_b.c0, src_a.c1, src_b.c1);
                dst.c1 = min_sum_inc(src_a.c0, src_b.c1, src_a.c1, src_b.c0);
            end
            default: dst = PAIR_INIT;
        endcase
    end

endmodule

// File: rtl/tev_obs_rules.sv
module tev_obs_rules
    import tev_pkg::*;
(
    input  gate_kind_e  kind,
    input  cost_t       obs_dst,
    input  drive_pair_t src_a,
    input  drive_pair_t src_b,
    output cost_t       cand_a,
    output cost_t       cand_b,
    output logic        uses_b
);

    always_comb begin
        uses_b = (kind != GK_NOT);
        case (kind)
            GK_AND: begin
                cand_a = add3(obs_dst, src_b.c1, COST_ONE);
                cand_b = add3(obs_dst, src_a.c1, COST_ONE);
            end
            GK_OR: begin
                cand_a = add3(obs_dst, src_b.c0, COST_ONE);
                cand_b = add3(obs_dst, src_a.c0, COST_ONE);
            end
            default: begin
                cand_a = add3(obs_dst, '0, COST_ONE);
                cand_b = add3(obs_dst, '0, COST_ONE);
            end
        endcase
    end

endmodule

// File: rtl/tev_evaluator.sv
module tev_evaluator
    import tev_pkg::*;
#(
    parameter int NODES     = 16,
    parameter int MAX_GATES = 16,
    localparam int NIDX_W   = $clog2(NODES),
    localparam int SLOT_W   = $clog2(MAX_GATES),
    localparam int CNT_W    = $clog2(MAX_GATES + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [SLOT_W-1:0] wr_slot,
    input  logic [1:0]        wr_kind,
    input  logic [NIDX_W-1:0] wr_src_a,
    input  logic [NIDX_W-1:0] wr_src_b,
    input  logic [NIDX_W-1:0] wr_dst,
    input  logic              start,
    input  logic [CNT_W-1:0]  num_gates,
    output logic              busy,
    output logic              done,
    input  logic [NIDX_W-1:0] rd_node,
    output logic [7:0]        rd_cost0,
    output logic [7:0]        rd_cost1,
    output logic [7:0]        rd_obs,
    output logic [7:0]        rd_test_sa0,
    output logic [7:0]        rd_test_sa1
);

    localparam logic [CNT_W-1:0] CNT_LIMIT = CNT_W'(MAX_GATES);

    phase_e            phase_q;
    logic [SLOT_W-1:0] gidx_q;
    logic [SLOT_W-1:0] last_q;
    logic              done_q;

    drive_pair_t drive_q [NODES];
    cost_t       obs_q   [NODES];
    logic        seen_q  [NODES];

    drive_pair_t drive_d [NODES];
    cost_t       obs_d   [NODES];
    logic        seen_d  [NODES];

    logic start_ok;
    assign start_ok = start && (phase_q == PH_IDLE);

    // ---------------- gate table ----------------
    gate_kind_e        g_kind;
    logic [NIDX_W-1:0] g_a, g_b, g_dst;

    tev_gate_table #(
        .SLOTS (MAX_GATES),
        .NIDX_W(NIDX_W),
        .SLOT_W(SLOT_W)
    ) u_table (
        .clk   (clk),
        .rst   (rst),
        .we    (wr_en && (phase_q == PH_IDLE)),
        .w_slot(wr_slot),
        .w_kind(gate_kind_e'(wr_kind)),
        .w_a   (wr_src_a),
        .w_b   (wr_src_b),
        .w_dst (wr_dst),
        .r_slot(gidx_q),
        .r_kind(g_kind),
        .r_a   (g_a),
        .r_b   (g_b),
        .r_dst (g_dst)
    );

    // ---------------- recurrence units ----------------
    drive_pair_t pair_a, pair_b, pair_y;
    cost_t       obs_y, cand_a, cand_b;
    logic        uses_b;

    assign pair_a = drive_q[g_a];
    assign pair_b = drive_q[g_b];
    assign obs_y  = obs_q[g_dst];

    tev_fwd_rules u_fwd (
        .kind (g_kind),
        .src_a(pair_a),
        .src_b(pair_b),
        .dst  (pair_y)
    );

    tev_obs_rules u_obs (
        .kind   (g_kind),
        .obs_dst(obs_y),
        .src_a  (pair_a),
        .src_b  (pair_b),
        .cand_a (cand_a),
        .cand_b (cand_b),
        .uses_b (uses_b)
    );

    // ---------------- node state update ----------------
    always_comb begin
        for (int n = 0; n < NODES; n++) begin
            drive_d[n] = drive_q[n];
            obs_d[n]   = obs_q[n];
            seen_d[n]  = seen_q[n];
        end
        if (start_ok) begin
            for (int n = 0; n < NODES; n++) begin
                drive_d[n] = PAIR_INIT;
                obs_d[n]   = COST_ONE;
                seen_d[n]  = 1'b0;
            end
        end else if (phase_q == PH_FWD) begin
            drive_d[g_dst] = pair_y;
        end else if (phase_q == PH_BWD) begin
            for (int n = 0; n < NODES; n++) begin
                if (NIDX_W'(n) == g_a) begin
                    obs_d[n]  = seen_d[n] ? cmin(obs_d[n], cand_a) : cand_a;
                    seen_d[n] = 1'b1;
                end
                if (uses_b && (NIDX_W'(n) == g_b)) begin
                    obs_d[n]  = seen_d[n] ? cmin(obs_d[n], cand_b) : cand_b;
                    seen_d[n] = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int n = 0; n < NODES; n++) begin
                drive_q[n] <= PAIR_INIT;
                obs_q[n]   <= COST_ONE;
                seen_q[n]  <= 1'b0;
            end
        end else begin
            for (int n = 0; n < NODES; n++) begin
                drive_q[n] <= drive_d[n];
                obs_q[n]   <= obs_d[n];
                seen_q[n]  <= seen_d[n];
            end
        end
    end

    // ---------------- sequencer ----------------
    logic [CNT_W-1:0] n_eff;
    assign n_eff = (num_gates > CNT_LIMIT) ? CNT_LIMIT : num_gates;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            gidx_q  <= '0;
            last_q  <= '0;
            done_q  <= 1'b0;
        end else begin
            case (phase_q)
                PH_IDLE: begin
                    if (start) begin
                        done_q <= 1'b0;
                        gidx_q <= '0;
                        last_q <= SLOT_W'(n_eff - CNT_W'(1));
                        phase_q <= (n_eff == '0) ? PH_FIN : PH_FWD;
                    end
                end
                PH_FWD: begin
                    if (gidx_q == last_q) begin
                        phase_q <= PH_BWD;
                    end else begin
                        gidx_q <= gidx_q + SLOT_W'(1);
                    end
                end
                PH_BWD: begin
                    if (gidx_q == '0) begin
                        phase_q <= PH_FIN;
                    end else begin
                        gidx_q <= gidx_q - SLOT_W'(1);
                    end
                end
                PH_FIN: begin
                    done_q  <= 1'b1;
                    phase_q <= PH_IDLE;
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    assign busy = (phase_q != PH_IDLE);
    assign done = done_q;

    // ---------------- read port ----------------
    drive_pair_t rd_pair;
    cost_t       rd_o;
    assign rd_pair     = drive_q[rd_node];
    assign rd_o        = obs_q[rd_node];
    assign rd_cost0    = rd_pair.c0;
    assign rd_cost1    = rd_pair.c1;
    assign rd_obs      = rd_o;
    assign rd_test_sa0 = add3(rd_pair.c1, rd_o, '0);
    assign rd_test_sa1 = add3(rd_pair.c0, rd_o, '0);

    // ---------------- assertions ----------------
    // R13
    bwd_done_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_BWD && gidx_q == '0) |-> ##2 done_q);

    // R13
    busy_not_done_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> !done);

    // R3
    fwd_growth_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_FWD) |-> (pair_y.c0 >= cost_t'(2) && pair_y.c1 >= cost_t'(2)));

    // R8
    obs_growth_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_BWD) |-> (cand_a > obs_y || cand_a == COST_MAX));

    // R11
    figure_floor_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_test_sa0 >= rd_obs) && (rd_test_sa1 >= rd_obs));

    // R13
    hold_results_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_IDLE && !start) ##1 $stable(rd_node)
            |-> ($stable(rd_cost0) && $stable(rd_cost1) && $stable(rd_obs)));

endmodule

// File: tb/sim_tev_evaluator.sv
`timescale 1ns/1ps
module sim_tev_evaluator;

    localparam int NODES = 16;
    localparam int MAXG  = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [3:0] wr_slot = '0;
    logic [1:0] wr_kind = '0;
    logic [3:0] wr_src_a = '0, wr_src_b = '0, wr_dst = '0;
    logic       start = 1'b0;
    logic [4:0] num_gates = '0;
    logic       busy, done;
    logic [3:0] rd_node = '0;
    logic [7:0] rd_cost0, rd_cost1, rd_obs, rd_test_sa0, rd_test_sa1;

    always #5 clk = ~clk;

    tev_evaluator #(.NODES(NODES), .MAX_GATES(MAXG)) u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_slot(wr_slot), .wr_kind(wr_kind),
        .wr_src_a(wr_src_a), .wr_src_b(wr_src_b), .wr_dst(wr_dst),
        .start(start), .num_gates(num_gates), .busy(busy), .done(done),
        .rd_node(rd_node), .rd_cost0(rd_cost0), .rd_cost1(rd_cost1), .rd_obs(rd_obs),
        .rd_test_sa0(rd_test_sa0), .rd_test_sa1(rd_test_sa1)
    );

    int checks = 0;
    int fails  = 0;

    // bench copy of the loaded table
    int g_kind[MAXG], g_a[MAXG], g_b[MAXG], g_dst[MAXG];
    // expected node values
    int m_c0[NODES], m_c1[NODES], m_o[NODES], m_rc[NODES], m_rk[NODES], m_dk[NODES];

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic int sat(input int v);
        return (v > 255) ? 255 : v;
    endfunction

    function automatic int imin(input int a, input int b);
        return (a < b) ? a : b;
    endfunction

    task automatic put_gate(input int slot, input int kind, input int a, input int b, input int dst);
        @(negedge clk);
        wr_en = 1'b1; wr_slot = 4'(slot); wr_kind = 2'(kind);
        wr_src_a = 4'(a); wr_src_b = 4'(b); wr_dst = 4'(dst);
        g_kind[slot] = kind; g_a[slot] = a; g_b[slot] = b; g_dst[slot] = dst;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic take_obs(input int n, input int c, input int kind);
        m_o[n]  = (m_rc[n] == 0) ? c : imin(m_o[n], c);
        m_rc[n] = m_rc[n] + 1;
        m_rk[n] = kind;
    endtask

    task automatic build_model(input int ng);
        for (int n = 0; n < NODES; n++) begin
            m_c0[n] = 1; m_c1[n] = 1; m_o[n] = 1; m_rc[n] = 0; m_rk[n] = 0; m_dk[n] = -1;
        end
        for (int g = 0; g < ng; g++) begin
            int a0, a1, b0, b1, y0, y1;
            a0 = m_c0[g_a[g]]; a1 = m_c1[g_a[g]];
            b0 = m_c0[g_b[g]]; b1 = m_c1[g_b[g]];
            case (g_kind[g])
                0: begin y0 = sat(imin(a0, b0) + 1); y1 = sat(a1 + b1 + 1); end
                1: begin y1 = sat(imin(a1, b1) + 1); y0 = sat(a0 + b0 + 1); end
                2: begin y0 = sat(a1 + 1); y1 = sat(a0 + 1); end
                default: begin y0 = sat(imin(a0 + b0, a1 + b1) + 1); y1 = sat(imin(a0 + b1, a1 + b0) + 1); end
            endcase
            m_c0[g_dst[g]] = y0; m_c1[g_dst[g]] = y1; m_dk[g_dst[g]] = g_kind[g];
        end
        for (int g = ng - 1; g >= 0; g--) begin
            int y, ca, cb;
            y = m_o[g_dst[g]];
            case (g_kind[g])
                0: begin ca = sat(y + m_c1[g_b[g]] + 1); cb = sat(y + m_c1[g_a[g]] + 1); end
                1: begin ca = sat(y + m_c0[g_b[g]] + 1); cb = sat(y + m_c0[g_a[g]] + 1); end
                default: begin ca = sat(y + 1); cb = sat(y + 1); end
            endcase
            take_obs(g_a[g], ca, g_kind[g]);
            if (g_kind[g] != 2) take_obs(g_b[g], cb, g_kind[g]);
        end
    endtask

    task automatic check_nodes();
        for (int n = 0; n < NODES; n++) begin
            string ct, ot;
            case (m_dk[n])
                0: ct = "R3";
                1: ct = "R4";
                2: ct = "R5";
                3: ct = "R6";
                default: ct = "R2";
            endcase
            if (m_rc[n] == 0) ot = "R7";
            else if (m_rc[n] > 1) ot = "R10";
            else if (m_rk[n] <= 1) ot = "R8";
            else ot = "R9";
            @(negedge clk);
            rd_node = 4'(n);
            #1;
            chk(rd_cost0 == 8'(m_c0[n]), ct, $sformatf("node %0d cost0", n), rd_cost0, m_c0[n]);
            chk(rd_cost1 == 8'(m_c1[n]), ct, $sformatf("node %0d cost1", n), rd_cost1, m_c1[n]);
            chk(rd_obs == 8'(m_o[n]), ot, $sformatf("node %0d obs", n), rd_obs, m_o[n]);
            chk(rd_test_sa0 == 8'(sat(m_c1[n] + m_o[n])), "R11", $sformatf("node %0d sa0", n),
                rd_test_sa0, sat(m_c1[n] + m_o[n]));
            chk(rd_test_sa1 == 8'(sat(m_c0[n] + m_o[n])), "R11", $sformatf("node %0d sa1", n),
                rd_test_sa1, sat(m_c0[n] + m_o[n]));
        end
    endtask

    // poke: during the run try a table write and a second start (R13)
    task automatic run(input int ng, input bit poke);
        int edges, expn;
        expn = (ng > MAXG) ? MAXG : ng;
        @(negedge clk);
        num_gates = 5'(ng); start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        edges = 1;
        chk(busy == 1'b1, "R13", "busy after start", busy, 1);
        chk(done == 1'b0, "R13", "done cleared by start", done, 0);
        if (poke && expn > 0) begin
            wr_en = 1'b1; wr_slot = '0; wr_kind = 2'((g_kind[0] + 1) % 4);
            wr_src_a = 4'(g_a[0]); wr_src_b = 4'(g_b[0]); wr_dst = 4'(g_dst[0]);
            start = 1'b1;
            @(posedge clk);
            @(negedge clk);
            wr_en = 1'b0; start = 1'b0;
            edges++;
        end
        while (!done && edges < 1000) begin
            @(posedge clk);
            @(negedge clk);
            edges++;
        end
        chk(edges == 2 * expn + 2, "R13", "edges until done", edges, 2 * expn + 2);
        chk(busy == 1'b0, "R13", "idle at done", busy, 0);
        repeat (3) @(negedge clk);
        chk(done == 1'b1, "R13", "done held", done, 1);
    endtask

    initial begin : watchdog
        #1_500_000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : stim
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk(done == 1'b0, "R1", "done", done, 0);
        chk(busy == 1'b0, "R1", "busy", busy, 0);
        for (int n = 0; n < 4; n++) begin
            rd_node = 4'(n);
            #1;
            chk(rd_cost0 == 8'd1 && rd_cost1 == 8'd1, "R1", "reset costs", {rd_cost0, rd_cost1}, 16'h0101);
            chk(rd_obs == 8'd1, "R1", "reset obs", rd_obs, 1);
            chk(rd_test_sa0 == 8'd2 && rd_test_sa1 == 8'd2, "R1", "reset figures", rd_test_sa0, 2);
            @(negedge clk);
        end

        // Directed mix: AND, OR, NOT (stray source B), XOR; node 3 read twice (R10)
        put_gate(0, 0, 0, 1, 3);
        put_gate(1, 1, 3, 2, 4);
        put_gate(2, 2, 4, 9, 5);
        put_gate(3, 3, 5, 3, 6);
        run(4, 1'b0);
        build_model(4);
        check_nodes();
        // hand values: node 3 AND(1,1): c0=2 c1=3 ; node 6 XOR output
        rd_node = 4'd3; #1;
        chk(rd_cost0 == 8'd2, "R3", "AND c0 hand", rd_cost0, 2);
        chk(rd_cost1 == 8'd3, "R3", "AND c1 hand", rd_cost1, 3);
        rd_node = 4'd9; #1;
        chk(rd_obs == 8'd1 && rd_cost0 == 8'd1, "R5", "stray source untouched", rd_obs, 1);

        // R14: fewer slots than loaded
        run(2, 1'b0);
        build_model(2);
        check_nodes();

        // R13: write and start during busy are dropped
        run(4, 1'b1);
        build_model(4);
        check_nodes();
        run(4, 1'b0);
        check_nodes();

        // R14: zero gates
        run(0, 1'b0);
        build_model(0);
        check_nodes();

        // R12: doubling chain saturates
        for (int g = 0; g < 9; g++) put_gate(g, 0, g, g, g + 1);
        run(9, 1'b0);
        build_model(9);
        rd_node = 4'd9; #1;
        chk(rd_cost1 == 8'd255, "R12", "saturated c1", rd_cost1, 255);
        chk(rd_test_sa0 == 8'd255, "R12", "saturated sa0", rd_test_sa0, 255);
        rd_node = 4'd8; #1;
        chk(rd_cost1 == 8'd255, "R12", "c1 at 511 clamps", rd_cost1, 255);
        check_nodes();

        // random topological netlists
        for (int t = 0; t < 25; t++) begin
            int p, ng;
            p  = 2 + int'($urandom % 4);
            ng = 1 + int'($urandom % (NODES - p));
            if (ng > MAXG) ng = MAXG;
            for (int g = 0; g < ng; g++)
                put_gate(g, int'($urandom % 4), int'($urandom % (p + g)),
                         int'($urandom % (p + g)), p + g);
            run(ng, 1'b0);
            build_model(ng);
            check_nodes();
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule